// File: doc/BRIEF.md
# Iterative 32-bit Integer ALU

A two-operand integer ALU with a request/valid handshake. The requester raises `req_i` with operands `a_i`, `b_i` and an operation code `op_i`, and keeps all of them unchanged until `valid_o` goes high. Bitwise operations and two's-complement add and subtract finish one cycle after the request is accepted. The three shifts take one clock per bit position. A working copy of the operand walks one position per clock while a down counter, loaded from the low five bits of `b_i`, counts the remaining steps. No barrel shifter is needed.

The result stays on `res_o` with `valid_o` high for as long as `req_i` stays high. Dropping `req_i` returns the block to idle with `valid_o` low on the next clock. A new request is accepted on the first clock edge at which `req_i` is high while the block is idle.

Top module: `iter_alu`

## Requirements
- R1: Operation codes on `op_i` are 0 = AND, 1 = OR, 2 = XOR, 3 = shift left, 4 = logical shift right, 5 = arithmetic shift right, 6 = add, 7 = subtract. For codes 0 to 2, `res_o` is the bitwise result, and `valid_o` rises one cycle after the accepting edge.
- R2: Codes 6 and 7 give `a_i + b_i` and `a_i - b_i` as two's-complement values wrapped modulo 2^32, with the same one-cycle latency as R1.
- R3: Code 3 shifts `a_i` left by `b_i[4:0]` and fills with zeros.
- R4: Code 4 shifts `a_i` right by `b_i[4:0]` and fills with zeros.
- R5: Code 5 shifts `a_i` right by `b_i[4:0]` and fills the vacated positions with `a_i[31]`.
- R6: For shifts, `b_i[31:5]` has no effect on the result or on the latency.
- R7: A shift by n positions raises `valid_o` n+1 cycles after the accepting edge, and `valid_o` stays low before that. A shift by 0 completes after one cycle.
- R8: While `req_i` stays high after `valid_o`, both `valid_o` and `res_o` hold. One cycle after `req_i` falls, `valid_o` is low.
- R9: After reset, `valid_o` is low and `res_o` is zero.
- R10: While the block is idle and `req_i` is low, `valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; low 5 bits give the shift amount |
| op_i | input | 3 | Operation code |
| req_i | input | 1 | Request; held high until `valid_o` is seen |
| res_o | output | 32 | Result |
| valid_o | output | 1 | Result ready |

## Verification
Counting from the edge that accepts a request, a non-shift result is due one cycle later. A shift by n is due n+1 cycles later. Each directed task drives the inputs on the falling edge and samples `valid_o` on every falling edge up to the due cycle, requiring it low before that cycle and high at it. The task then compares `res_o` against a model computed with language operators. After the result, the task holds `req_i` for one more cycle, drops it, and checks that `valid_o` falls on the next falling edge.

// File: rtl/iter_alu_pkg.sv
package iter_alu_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_SHL = 3'd3,
    OP_SHR = 3'd4,
    OP_SAR = 3'd5,
    OP_ADD = 3'd6,
    OP_SUB = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } alu_st_e;

  function automatic logic is_shift(alu_op_e op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
  endfunction
endpackage

// File: rtl/iter_alu_quick.sv
module iter_alu_quick
  import iter_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/iter_alu_step.sv
module iter_alu_step
  import iter_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] work_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] work_o
);
  always_comb begin
    unique case (op_i)
      OP_SHL:  work_o = {work_i[W-2:0], 1'b0};
      OP_SHR:  work_o = {1'b0, work_i[W-1:1]};
      OP_SAR:  work_o = {work_i[W-1], work_i[W-1:1]};
      default: work_o = work_i;
    endcase
  end
endmodule

// File: rtl/iter_alu_count.sv
module iter_alu_count #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R7: each step removes exactly one position
  assert_cnt_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && !zero_o) |=> (cnt_o == $past(cnt_o) - 1'b1));
endmodule

// File: rtl/iter_alu.sv
module iter_alu
  import iter_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [2:0]    op_i,
  input  logic          req_i,
  output logic [W-1:0]  res_o,
  output logic          valid_o
);
  alu_st_e       st_q, st_d;
  alu_op_e       op_q, op_in;
  logic [W-1:0]  work_q, work_d, quick_res, step_res;
  logic [CW-1:0] cnt;
  logic          cnt_zero, cnt_load, cnt_dec, accept;

  assign op_in  = alu_op_e'(op_i);
  assign accept = (st_q == ST_IDLE) && req_i;

  iter_alu_quick #(.W(W)) u_quick (
    .a_i(a_i), .b_i(b_i), .op_i(op_in), .res_o(quick_res)
  );

  iter_alu_step #(.W(W)) u_step (
    .work_i(work_q), .op_i(op_q), .work_o(step_res)
  );

  assign cnt_load = accept && is_shift(op_in);
  assign cnt_dec  = (st_q == ST_SHIFT) && req_i && !cnt_zero;

  iter_alu_count #(.CW(CW)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cnt_load),
    .load_val_i(b_i[CW-1:0]), .dec_i(cnt_dec),
    .cnt_o(cnt), .zero_o(cnt_zero)
  );

  always_comb begin
    st_d   = st_q;
    work_d = work_q;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        if (is_shift(op_in)) begin
          work_d = a_i;
          st_d   = ST_SHIFT;
        end else begin
          work_d = quick_res;
          st_d   = ST_DONE;
        end
      end
      ST_SHIFT: begin
        if (!req_i)        st_d   = ST_IDLE;
        else if (cnt_zero) st_d   = ST_DONE;
        else               work_d = step_res;
      end
      ST_DONE: if (!req_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_AND;
      work_q <= '0;
    end else begin
      st_q   <= st_d;
      work_q <= work_d;
      if (accept) op_q <= op_in;
    end
  end

  assign res_o   = work_q;
  assign valid_o = (st_q == ST_DONE) || ((st_q == ST_SHIFT) && cnt_zero);

  // R1 / R2: non-shift requests complete one cycle after acceptance
  assert_quick_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !is_shift(op_in)) |=> valid_o);

  // R8: result held while the request stays up
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && req_i) |=> (valid_o && $stable(res_o)));

  // R8: dropping the request ends valid
  assert_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !req_i) |=> !valid_o);

  // R10: idle without request stays quiet
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_IDLE) && !req_i) |=> !valid_o);

  // R5: sign bit kept during arithmetic right shift
  assert_sar_sign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_SHIFT) && (op_q == OP_SAR) && req_i) |=> $stable(work_q[W-1]));
endmodule

// File: tb/sim_iter_alu.sv
module sim_iter_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [2:0]  op = '0;
  logic        req = 1'b0;
  logic [31:0] res;
  logic        valid;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  iter_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .op_i(op),
    .req_i(req), .res_o(res), .valid_o(valid)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [2:0] o, logic [31:0] x, logic [31:0] y);
    case (o)
      3'd0: return x & y;
      3'd1: return x | y;
      3'd2: return x ^ y;
      3'd3: return x << y[4:0];
      3'd4: return x >> y[4:0];
      3'd5: return $unsigned($signed(x) >>> y[4:0]);
      3'd6: return x + y;
      default: return x - y;
    endcase
  endfunction

  // one full request: latency, result, hold, release
  task automatic run_op(string rq, logic [2:0] o, logic [31:0] x, logic [31:0] y);
    int lat;
    lat = (o >= 3'd3 && o <= 3'd5) ? int'(y[4:0]) + 1 : 1;
    @(negedge clk);
    a = x; b = y; op = o; req = 1'b1;
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      if (i < lat && valid) chk({rq, " early valid R7"}, 32'(valid), 32'd0);
    end
    chk({rq, " valid due"}, 32'(valid), 32'd1);
    chk({rq, " result"}, res, model(o, x, y));
    @(negedge clk);
    chk({rq, " hold R8"}, {res[30:0], valid}, {model(o, x, y), 1'b1} & 32'hFFFF_FFFF);
    req = 1'b0;
    @(negedge clk);
    chk({rq, " drop R8"}, 32'(valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("reset valid R9", 32'(valid), 32'd0);
    chk("reset result R9", res, 32'd0);
  endtask

  task automatic t_logic;
    run_op("AND R1", 3'd0, 32'hF0F0_1234, 32'h0FF0_FF00);
    run_op("OR R1",  3'd1, 32'h8000_0001, 32'h0000_FF00);
    run_op("XOR R1", 3'd2, 32'hDEAD_BEEF, 32'hFFFF_0000);
  endtask

  task automatic t_arith;
    run_op("ADD wrap R2", 3'd6, 32'h7FFF_FFFF, 32'h0000_0001);
    run_op("ADD neg R2",  3'd6, 32'hFFFF_FFFE, 32'hFFFF_FFFD);
    run_op("SUB wrap R2", 3'd7, 32'h8000_0000, 32'h0000_0001);
    run_op("SUB R2",      3'd7, 32'h0000_0005, 32'h0000_0009);
  endtask

  task automatic t_shifts;
    run_op("SHL R3", 3'd3, 32'h0000_00F1, 32'd4);
    run_op("SHL 31 R3", 3'd3, 32'h0000_0003, 32'd31);
    run_op("SHR R4", 3'd4, 32'hF000_0000, 32'd7);
    run_op("SAR R5", 3'd5, 32'h8000_0010, 32'd4);
    run_op("SAR 31 R5", 3'd5, 32'h9000_0000, 32'd31);
    run_op("SAR pos R5", 3'd5, 32'h4000_0000, 32'd3);
    run_op("SHL zero R7", 3'd3, 32'h1234_5678, 32'd0);
  endtask

  task automatic t_upper_b;
    run_op("SHR upper R6", 3'd4, 32'hFFFF_0000, 32'hFFFF_FFE3);
    run_op("SAR upper R6", 3'd5, 32'h8000_0000, 32'h8000_0020);
  endtask

  task automatic t_idle;
    req = 1'b0; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; op = 3'd1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("idle R10", 32'(valid), 32'd0);
    end
  endtask

  initial begin
    #5 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_logic();
    t_arith();
    t_shifts();
    t_upper_b();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule